// File: doc/BRIEF.md
# DMA Interrupt-Priority Hold Controller

This block decides when a DMA engine has to stop issuing bus transfers so that an urgent interrupt can be serviced first. It watches a non-maskable interrupt line and a set of pending interrupt requests, each of which carries a 5-bit priority level. It compares every pending level against a programmable threshold. When any such source qualifies, it drives a registered hold signal to the DMA engine.

Software can keep the engine held after it clears the interrupt flag that caused the stall. It does this through a small suppress counter, which it raises by one and lowers by one with register-write strobes. The hold stays asserted while that counter is nonzero. The transfer resumes only once no qualifying interrupt remains pending and the counter has returned to zero, so nested interrupt handlers each keep the engine quiet until the last one is done. Counter steps past either end saturate and record a sticky error.

Top module: `dma_irq_hold_ctrl`

## Requirements
- R1: When `nmi_i` is high in a cycle, `hold_o` is high after the next rising clock edge.
- R2: Request i is pending when `irq_pend_i[i]` is 1. Its level is `irq_lvl_i[i*5 +: 5]`, and a smaller value means more urgent. A pending request whose level is strictly below `thresh_i` causes `hold_o` to be high after the next edge. A level equal to or above the threshold has no effect, and so does a request that is not pending.
- R3: `hold_o` is low after the edge that follows a cycle with no NMI, no qualifying request and a suppress count of zero. In that case the transfer resumes with one cycle of delay.
- R4: While `sup_cnt_o` is nonzero, `hold_o` is high on the next cycle whatever the interrupt inputs are.
- R5: `sup_inc_i` alone raises the suppress count by one, and `sup_dec_i` alone lowers it by one. The count changes on the edge that samples the strobe. When both strobes are high in the same cycle, the count does not change.
- R6: An increment at 15 leaves the count at 15, and a decrement at 0 leaves it at 0. Either of these sets `sup_err_o`, which then stays high until reset.
- R7: `paused_o` always equals `hold_o`.
- R8: With several qualifying requests pending at once, `hold_o` stays high until the last of them is withdrawn.
- R9: After reset, `hold_o`, `paused_o`, `sup_cnt_o` and `sup_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_pend_i | input | 8 | Pending flag of each interrupt request |
| irq_lvl_i | input | 40 | Packed 5-bit priority levels, request i at bits i*5+4:i*5 |
| thresh_i | input | 5 | Priority threshold; levels strictly below it qualify |
| sup_inc_i | input | 1 | Suppress counter increment strobe |
| sup_dec_i | input | 1 | Suppress counter decrement strobe |
| hold_o | output | 1 | Registered hold request to the DMA engine |
| paused_o | output | 1 | Status copy of the hold output |
| sup_cnt_o | output | 4 | Current suppress count |
| sup_err_o | output | 1 | Sticky saturation error |

## Verification
A wrong comparison in the level qualifier, for example an off-by-one at the threshold or an inverted sense of urgency, shows on `hold_o` one cycle after the request pattern is applied. A suppress count that has drifted shows on `sup_cnt_o` right after the strobe edge. The same drift also shows as a hold that fails to release, one cycle after the interrupts go quiet. A lost or spurious saturation event shows on `sup_err_o` after the offending strobe and stays visible from then on. These effects make every internal error observable within two cycles.

// File: rtl/dmahold_pkg.sv
package dmahold_pkg;

  typedef enum logic [1:0] {
    STEP_KEEP = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Both strobes together cancel out.
  function automatic step_e decode_step(input logic inc, input logic dec);
    if (inc && !dec)      return STEP_UP;
    else if (dec && !inc) return STEP_DOWN;
    else                  return STEP_KEEP;
  endfunction

endpackage

// File: rtl/dmahold_qualify.sv
module dmahold_qualify #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 5
) (
  input  logic                     nmi,
  input  logic [NUM_IRQ-1:0]       pend,
  input  logic [NUM_IRQ*LVL_W-1:0] lvls,
  input  logic [LVL_W-1:0]         thresh,
  output logic                     qual_any,
  output logic                     stall_req
);

  // Smaller level value is more urgent; strict comparison.
  function automatic logic is_urgent(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] thr);
    return lvl < thr;
  endfunction

  logic [NUM_IRQ-1:0] qual_vec;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cmp
      assign qual_vec[i] = pend[i] & is_urgent(lvls[i*LVL_W +: LVL_W], thresh);
    end
  endgenerate

  assign qual_any  = |qual_vec;
  assign stall_req = nmi | qual_any;

endmodule

// File: rtl/dmahold_supcnt.sv
module dmahold_supcnt
  import dmahold_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             err,
  output logic             sat_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input step_e s);
    case (s)
      STEP_UP:   return (c == CNT_MAX) ? c : c + 1'b1;
      STEP_DOWN: return (c == '0) ? c : c - 1'b1;
      default:   return c;
    endcase
  endfunction

  function automatic logic hits_limit(input logic [CNT_W-1:0] c, input step_e s);
    return ((s == STEP_UP) && (c == CNT_MAX)) || ((s == STEP_DOWN) && (c == '0));
  endfunction

  step_e step;
  assign step    = decode_step(inc, dec);
  assign sat_hit = hits_limit(cnt, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      cnt <= next_count(cnt, step);
      if (sat_hit) err <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_irq_hold_ctrl.sv
module dma_irq_hold_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 5,
  parameter int CNT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     nmi_i,
  input  logic [NUM_IRQ-1:0]       irq_pend_i,
  input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl_i,
  input  logic [LVL_W-1:0]         thresh_i,
  input  logic                     sup_inc_i,
  input  logic                     sup_dec_i,
  output logic                     hold_o,
  output logic                     paused_o,
  output logic [CNT_W-1:0]         sup_cnt_o,
  output logic                     sup_err_o
);

  logic qual_any;
  logic stall_req;
  logic sup_active;
  logic sat_hit;
  logic hold_next;
  logic hold_q;

  dmahold_qualify #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_qual (
    .nmi       (nmi_i),
    .pend      (irq_pend_i),
    .lvls      (irq_lvl_i),
    .thresh    (thresh_i),
    .qual_any  (qual_any),
    .stall_req (stall_req)
  );

  dmahold_supcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (sup_inc_i),
    .dec     (sup_dec_i),
    .cnt     (sup_cnt_o),
    .err     (sup_err_o),
    .sat_hit (sat_hit)
  );

  assign sup_active = |sup_cnt_o;
  assign hold_next  = stall_req | sup_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next;
  end

  assign hold_o   = hold_q;
  assign paused_o = hold_q;

endmodule

module dmahold_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_i,
  input logic             qual_any,
  input logic             sup_inc_i,
  input logic             sup_dec_i,
  input logic             sat_hit,
  input logic             hold_o,
  input logic             paused_o,
  input logic [CNT_W-1:0] sup_cnt_o,
  input logic             sup_err_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r1_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> hold_o);

  a_r2_urgent_holds: assert property (@(posedge clk) disable iff (!rst_n)
    qual_any |=> hold_o);

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_i && !qual_any && sup_cnt_o == '0) |=> !hold_o);

  a_r4_suppress_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_cnt_o != '0) |=> hold_o);

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_inc_i && !sup_dec_i && sup_cnt_o != CMAX) |=> sup_cnt_o == $past(sup_cnt_o) + 1'b1);

  a_r5_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_inc_i && sup_dec_i) |=> $stable(sup_cnt_o));

  a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_inc_i && !sup_dec_i && sup_cnt_o == CMAX) |=> (sup_cnt_o == CMAX && sup_err_o));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sup_err_o |=> sup_err_o);

  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_err_o) |-> $past(sat_hit));

  a_r7_paused_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    paused_o == hold_o);

endmodule

bind dma_irq_hold_ctrl dmahold_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nmi_i     (nmi_i),
  .qual_any  (qual_any),
  .sup_inc_i (sup_inc_i),
  .sup_dec_i (sup_dec_i),
  .sat_hit   (sat_hit),
  .hold_o    (hold_o),
  .paused_o  (paused_o),
  .sup_cnt_o (sup_cnt_o),
  .sup_err_o (sup_err_o)
);

// File: tb/tb_dma_irq_hold_ctrl.sv
module tb_dma_irq_hold_ctrl;

  localparam int N  = 8;
  localparam int LW = 5;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nmi = 1'b0;
  logic [N-1:0]  pend = '0;
  logic [N*LW-1:0] lvls = '0;
  logic [LW-1:0] thr = '0;
  logic          inc = 1'b0;
  logic          dec = 1'b0;
  logic          hold, paused, err;
  logic [CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] m_cnt;
  logic          m_err;
  logic          m_hold;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  dma_irq_hold_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_pend_i(pend), .irq_lvl_i(lvls),
    .thresh_i(thr), .sup_inc_i(inc), .sup_dec_i(dec), .hold_o(hold),
    .paused_o(paused), .sup_cnt_o(cnt), .sup_err_o(err)
  );

  // Bench's own view: any pending source with level under threshold
  function automatic bit any_urgent(input logic [N-1:0] p, input logic [N*LW-1:0] l,
                                    input logic [LW-1:0] t);
    bit r = 0;
    for (int k = 0; k < N; k++)
      if (p[k] && (int'(l[k*LW +: LW]) < int'(t))) r = 1;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Inputs are already driven (at a negedge); run one edge, check at next negedge.
  task automatic cycle();
    string htag;
    bit u = any_urgent(pend, lvls, thr);
    string ctag;
    htag = nmi ? "R1" : (u ? "R2" : ((m_cnt != 0) ? "R4" : "R3"));
    m_hold = nmi | u | (m_cnt != 0);
    ctag = "R5";
    if (inc && !dec) begin
      if (m_cnt == 4'hF) begin m_err = 1; ctag = "R6"; end else m_cnt = m_cnt + 1;
    end else if (dec && !inc) begin
      if (m_cnt == 4'h0) begin m_err = 1; ctag = "R6"; end else m_cnt = m_cnt - 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(htag, "hold_o", hold, m_hold);
    chk("R7", "paused_o", paused, hold);
    chk(ctag, "sup_cnt_o", cnt, m_cnt);
    chk("R6", "sup_err_o", err, m_err);
  endtask

  task automatic set_lvl(input int idx, input int v);
    lvls[idx*LW +: LW] = LW'(v);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    m_cnt = 0; m_err = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "hold_o", hold, 0);
    chk("R9", "paused_o", paused, 0);
    chk("R9", "sup_cnt_o", cnt, 0);
    chk("R9", "sup_err_o", err, 0);

    // R2 threshold boundary: level == threshold does not qualify
    thr = 5'd10; set_lvl(3, 10); pend = 8'b0000_1000;
    cycle();
    chk("R2", "equal level ignored", hold, 0);
    set_lvl(3, 9);
    cycle();
    chk("R2", "level below threshold holds", hold, 1);
    pend = '0; set_lvl(5, 0);   // not pending: ignored
    cycle();
    chk("R3", "release after clear", hold, 0);

    // R8 nested: two qualifying, withdraw one at a time
    thr = 5'd20; set_lvl(1, 3); set_lvl(6, 15); pend = 8'b0100_0010;
    cycle();
    pend = 8'b0100_0000;
    cycle();
    chk("R8", "still held with one left", hold, 1);
    pend = '0;
    cycle();
    chk("R8", "released after last", hold, 0);

    // R1 NMI
    nmi = 1; cycle(); nmi = 0; cycle();

    // R4 suppress counter holds with no interrupts; R6 saturation at 0
    dec = 1; cycle(); dec = 0;
    chk("R6", "underflow sets error", err, 1);
    inc = 1; cycle(); inc = 0; cycle();
    chk("R4", "held by counter", hold, 1);
    inc = 1; dec = 1; cycle(); inc = 0; dec = 0;
    chk("R5", "both strobes keep", cnt, 1);
    inc = 1; repeat (16) cycle(); inc = 0;
    chk("R6", "saturated at top", cnt, 15);
    dec = 1; repeat (15) cycle(); dec = 0; cycle();
    chk("R3", "release at zero count", hold, 0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      nmi  = ($urandom_range(0, 15) == 0);
      pend = ($urandom_range(0, 2) == 0) ? N'($urandom()) : '0;
      lvls = {$urandom(), $urandom()};
      thr  = LW'($urandom_range(0, 31));
      inc  = ($urandom_range(0, 5) == 0);
      dec  = ($urandom_range(0, 4) == 0);
      cycle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule